// File: doc/BRIEF.md
# Multi-Port Flash Read Line Buffer

This block keeps one line of flash contents close to several read initiators. Each initiator port compares its own request address with the tag of the stored line. When the line is valid and the tag matches, the port receives its 32-bit word and ECC nibble in the same cycle, and the flash bank is not touched. Any number of ports can hit at once.

A request that misses starts a single line fetch from the bank, or from the bank pair when the two banks are interleaved. When the fetched line returns, the requested word goes straight to the waiting port, and the whole line is written into the buffer under its new tag. Misses that arrive together are taken one at a time, and the other missing ports wait until their own turn comes. ECC bits travel with the data so that the requester can check them. The requester gets back the word address of the data it receives, and can use that address in its ECC check.

The `buf_en` input turns buffering on and off. The `flush` input drops the stored line. The valid bit is cleared only by reset or by a flush, and a flush that arrives while a fetch is in flight also stops that fetch from marking its line valid.

Top module: `flash_line_buf`

## Requirements
- R1: With INTERLEAVE=1 a line holds 256 data bits and 32 ECC bits (8 words). With INTERLEAVE=0 it holds 128 data bits and 16 ECC bits (4 words). The line address is the word address with its low 3 (or 2) offset bits removed, so lines are 256-bit (or 128-bit) aligned. Word w of a line sits at data bits [32w+31:32w] and ECC bits [4w+3:4w].
- R2: While `buf_en` is 0 no request hits, and every request starts a bank fetch. A fill made while `buf_en` is 0 leaves the stored line, its tag and its valid bit unchanged.
- R3: A request hits when its address bits above the line offset equal the stored tag and the valid bit is set. A hit is answered in the same cycle as the request (zero wait states).
- R4: A hit starts no bank fetch.
- R5: Each response carries the requested word, the 4 ECC bits of that word, and an echo of the request's word address.
- R6: All ports that hit in the same cycle are answered in that cycle.
- R7: A miss raises `bank_req` for one cycle with `bank_addr` equal to the line address. The requester is answered in the cycle in which `bank_rvalid` is 1. The line, its tag and the valid bit are then updated, so that a later request to the same line hits. Only one fetch is in flight at a time.
- R8: In interleaved mode `bank_rdata[127:0]` holds words 0 to 3 of the line (first bank) and `bank_rdata[255:128]` holds words 4 to 7 (second bank).
- R9: The valid bit is clear after reset and is cleared by a one-cycle `flush` pulse. Nothing else clears it.
- R10: A flush that arrives while a fetch is in flight leaves the valid bit clear when that fetch completes.
- R11: Misses that arrive together are fetched one at a time, lowest port index first. A waiting port gets no response until its own fetch returns.
- R12: `rsp_valid[i]` is 1 only while `req_valid[i]` is 1, and `req_ready[i]` equals `rsp_valid[i]`. The requester holds `req_valid` and `req_addr` steady until a cycle in which `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_en | input | 1 | Buffering enable |
| flush | input | 1 | One-cycle pulse that invalidates the line |
| req_valid | input | NPORT | Per-port request valid |
| req_addr | input | NPORT*ADDR_W | Per-port word address (32-bit words) |
| req_ready | output | NPORT | Per-port request accepted |
| rsp_valid | output | NPORT | Per-port response valid |
| rsp_data | output | NPORT*32 | Per-port returned word |
| rsp_ecc | output | NPORT*4 | Per-port ECC bits of the returned word |
| rsp_addr | output | NPORT*ADDR_W | Per-port echoed word address |
| bank_req | output | 1 | Line fetch start pulse |
| bank_addr | output | ADDR_W-OFF_W | Line address of the fetch |
| bank_rvalid | input | 1 | Fetched line is present on the bank data inputs |
| bank_rdata | input | LINE_W | Fetched line data |
| bank_recc | input | LINE_W/8 | Fetched line ECC bits |

## Verification
The stimulus starts with a cold miss, which shows that a line is fetched and forwarded, and that the bank address carries the line address. Next come hits on the top and bottom words of the line, which show that the two bank halves are placed where they belong and that no wait state or fetch occurs. All ports then hit the line in the same cycle. A mixed pattern follows: one hit and two misses to different lines. It separates the zero-wait hit from the lowest-index-first order in which the misses are served. The remaining patterns exercise buffering with the enable off, a flush between reads and a flush during a fetch. Each of them shows whether the next read of the same line is served from the buffer or from the bank.

// File: rtl/flash_line_buf.sv
module flash_line_buf #(
  parameter int NPORT      = 3,
  parameter int ADDR_W     = 20,
  parameter int INTERLEAVE = 1,
  localparam int LINE_W = (INTERLEAVE != 0) ? 256 : 128,
  localparam int WORDS  = LINE_W / 32,
  localparam int ECC_W  = LINE_W / 8,
  localparam int EPW    = ECC_W / WORDS,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    buf_en,
  input  logic                    flush,
  input  logic [NPORT-1:0]        req_valid,
  input  logic [NPORT*ADDR_W-1:0] req_addr,
  output logic [NPORT-1:0]        req_ready,
  output logic [NPORT-1:0]        rsp_valid,
  output logic [NPORT*32-1:0]     rsp_data,
  output logic [NPORT*EPW-1:0]    rsp_ecc,
  output logic [NPORT*ADDR_W-1:0] rsp_addr,
  output logic                    bank_req,
  output logic [TAG_W-1:0]        bank_addr,
  input  logic                    bank_rvalid,
  input  logic [LINE_W-1:0]       bank_rdata,
  input  logic [ECC_W-1:0]        bank_recc
);
  localparam int PID_W = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [LINE_W-1:0] line_q;
  logic [ECC_W-1:0]  ecc_q;
  logic [TAG_W-1:0]  tag_q, fetch_tag_q;
  logic              valid_q, busy_q, flush_pend_q;
  logic [PID_W-1:0]  owner_q, sel;
  logic              found;
  logic [NPORT-1:0]  hit, miss;
  logic [ADDR_W-1:0] addr_a [NPORT];

  wire fill_done = busy_q & bank_rvalid;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    wire [OFF_W-1:0] off   = addr_a[i][OFF_W-1:0];
    wire             fwd   = fill_done & (owner_q == PID_W'(i));
    assign addr_a[i] = req_addr[i*ADDR_W +: ADDR_W];
    assign hit[i]    = buf_en & valid_q & (addr_a[i][ADDR_W-1:OFF_W] == tag_q);
    assign miss[i]   = req_valid[i] & ~hit[i];
    assign rsp_valid[i] = req_valid[i] & (hit[i] | fwd);
    assign req_ready[i] = rsp_valid[i];
    assign rsp_data[i*32 +: 32]   = hit[i] ? line_q[32*off +: 32] : bank_rdata[32*off +: 32];
    assign rsp_ecc[i*EPW +: EPW]  = hit[i] ? ecc_q[EPW*off +: EPW] : bank_recc[EPW*off +: EPW];
    assign rsp_addr[i*ADDR_W +: ADDR_W] = addr_a[i];
  end

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NPORT; i++)
      if (miss[i] && !found) begin
        sel   = PID_W'(i);
        found = 1'b1;
      end
  end

  assign bank_req  = ~busy_q & found;
  assign bank_addr = addr_a[sel][ADDR_W-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q       <= '0;
      ecc_q        <= '0;
      tag_q        <= '0;
      fetch_tag_q  <= '0;
      valid_q      <= 1'b0;
      busy_q       <= 1'b0;
      flush_pend_q <= 1'b0;
      owner_q      <= '0;
    end else begin
      if (bank_req) begin
        busy_q       <= 1'b1;
        owner_q      <= sel;
        fetch_tag_q  <= bank_addr;
        flush_pend_q <= 1'b0;
      end else if (fill_done) begin
        busy_q <= 1'b0;
      end
      if (busy_q && flush) flush_pend_q <= 1'b1;
      if (fill_done && buf_en) begin
        line_q <= bank_rdata;
        ecc_q  <= bank_recc;
        tag_q  <= fetch_tag_q;
      end
      if (flush) valid_q <= 1'b0;
      else if (fill_done && buf_en) valid_q <= ~flush_pend_q;
    end
  end

  AST_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !bank_req); // R7
  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done && buf_en && !flush && !flush_pend_q |=> valid_q && tag_q == $past(fetch_tag_q)); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !valid_q); // R9
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !flush |=> valid_q); // R9
  AST_FLUSH_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done && flush_pend_q |=> !valid_q); // R10
  AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en && !fill_done |-> rsp_valid == '0); // R2
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid & ~req_valid) == '0); // R12
endmodule

// File: tb/flash_line_buf_tb.sv
module flash_line_buf_tb;
  localparam int NP = 3, AW = 20, LAT = 4, TW = 17;

  logic clk = 1'b0, rst_n = 1'b0, buf_en = 1'b1, flush = 1'b0;
  logic [NP-1:0] req_valid = '0, req_ready, rsp_valid;
  logic [NP*AW-1:0] req_addr = '0, rsp_addr;
  logic [NP*32-1:0] rsp_data;
  logic [NP*4-1:0] rsp_ecc;
  logic bank_req, bank_rvalid;
  logic [TW-1:0] bank_addr, fl_line;
  logic [255:0] bank_rdata;
  logic [31:0] bank_recc;
  int cnt, fetches, errors = 0, checks = 0;
  int done_cyc [NP];
  logic [TW-1:0] last_bank_addr;

  always #5 clk = ~clk;

  flash_line_buf #(.NPORT(NP), .ADDR_W(AW), .INTERLEAVE(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .flush(flush),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ecc(rsp_ecc), .rsp_addr(rsp_addr),
    .bank_req(bank_req), .bank_addr(bank_addr), .bank_rvalid(bank_rvalid),
    .bank_rdata(bank_rdata), .bank_recc(bank_recc));

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return {12'hF1A, a};
  endfunction
  function automatic logic [3:0] epat(input logic [AW-1:0] a);
    return a[3:0] ^ a[7:4] ^ 4'h9;
  endfunction

  always_comb
    for (int w = 0; w < 8; w++) begin
      bank_rdata[32*w +: 32] = pat({fl_line, 3'(w)});
      bank_recc[4*w +: 4]    = epat({fl_line, 3'(w)});
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 0; bank_rvalid <= 1'b0; fetches <= 0; fl_line <= '0; last_bank_addr <= '0;
    end else begin
      bank_rvalid <= 1'b0;
      if (bank_req) begin
        cnt <= LAT; fl_line <= bank_addr; last_bank_addr <= bank_addr; fetches <= fetches + 1;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) bank_rvalid <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_ports(input logic [NP-1:0] mask, input logic [AW-1:0] a0, a1, a2,
                           input string tag);
    logic [NP-1:0] pend = mask, now;
    logic [AW-1:0] ad [NP];
    int cyc = 0;
    ad[0] = a0; ad[1] = a1; ad[2] = a2;
    for (int p = 0; p < NP; p++) done_cyc[p] = -1;
    @(negedge clk);
    req_addr  = {a2, a1, a0};
    req_valid = mask;
    while (pend != 0 && cyc < 100) begin
      #1;
      now = '0;
      chk(req_ready == rsp_valid && (rsp_valid & ~req_valid) == 0, "R12", "ready/valid",
          {req_ready, rsp_valid}, {rsp_valid, rsp_valid});
      for (int p = 0; p < NP; p++)
        if (pend[p] && rsp_valid[p]) begin
          done_cyc[p] = cyc; now[p] = 1'b1; pend[p] = 1'b0;
          chk(rsp_data[p*32 +: 32] == pat(ad[p]), tag, "data", rsp_data[p*32 +: 32], pat(ad[p]));
          chk(rsp_ecc[p*4 +: 4] == epat(ad[p]), "R5", "ecc", rsp_ecc[p*4 +: 4], epat(ad[p]));
          chk(rsp_addr[p*AW +: AW] == ad[p], "R5", "addr echo", rsp_addr[p*AW +: AW], ad[p]);
        end
      @(negedge clk);
      req_valid = req_valid & ~now;
      cyc++;
    end
    chk(pend == 0, tag, "unserved ports", pend, 0);
    req_valid = '0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(rsp_valid == 0 && req_ready == 0 && bank_req == 0, "R12", "reset outputs",
        {rsp_valid, req_ready, bank_req}, 0);
  endtask

  task automatic t_cold_miss;
    int f0 = fetches;
    run_ports(3'b001, 20'h00123, 0, 0, "R7");
    chk(done_cyc[0] == LAT + 1, "R9", "cold miss latency", done_cyc[0], LAT + 1);
    chk(fetches - f0 == 1, "R7", "one fetch", fetches - f0, 1);
    chk(last_bank_addr == 17'(20'h00123 >> 3), "R1", "line address", last_bank_addr, 20'h00123 >> 3);
  endtask

  task automatic t_hits;
    int f0 = fetches;
    run_ports(3'b001, 20'h00127, 0, 0, "R8");
    chk(done_cyc[0] == 0, "R3", "upper half hit wait", done_cyc[0], 0);
    run_ports(3'b010, 0, 20'h00120, 0, "R8");
    chk(done_cyc[1] == 0, "R3", "lower half hit wait", done_cyc[1], 0);
    chk(fetches == f0, "R4", "no fetch on hit", fetches - f0, 0);
  endtask

  task automatic t_multi_hit;
    int f0 = fetches;
    run_ports(3'b111, 20'h00121, 20'h00124, 20'h00126, "R6");
    for (int p = 0; p < NP; p++)
      chk(done_cyc[p] == 0, "R6", "parallel hit", done_cyc[p], 0);
    chk(fetches == f0, "R4", "no fetch", fetches - f0, 0);
  endtask

  task automatic t_disabled;
    int f0 = fetches;
    buf_en = 1'b0;
    run_ports(3'b001, 20'h00122, 0, 0, "R2");
    chk(done_cyc[0] == LAT + 1, "R2", "disabled goes to bank", done_cyc[0], LAT + 1);
    chk(fetches - f0 == 1, "R2", "disabled fetch count", fetches - f0, 1);
    buf_en = 1'b1;
    run_ports(3'b001, 20'h00122, 0, 0, "R2");
    chk(done_cyc[0] == 0, "R2", "line kept after disable", done_cyc[0], 0);
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    run_ports(3'b001, 20'h00125, 0, 0, "R9");
    chk(done_cyc[0] == LAT + 1, "R9", "miss after flush", done_cyc[0], LAT + 1);
    run_ports(3'b001, 20'h00125, 0, 0, "R7");
    chk(done_cyc[0] == 0, "R7", "hit after refill", done_cyc[0], 0);
  endtask

  task automatic t_flush_in_fill;
    int f0 = fetches;
    fork
      run_ports(3'b001, 20'h00345, 0, 0, "R10");
      begin
        repeat (2) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
      end
    join
    run_ports(3'b001, 20'h00346, 0, 0, "R10");
    chk(done_cyc[0] == LAT + 1, "R10", "line stays invalid", done_cyc[0], LAT + 1);
    chk(fetches - f0 == 2, "R10", "refetch count", fetches - f0, 2);
  endtask

  task automatic t_arb;
    int f0 = fetches;
    run_ports(3'b111, 20'h00341, 20'h00500, 20'h00600, "R11");
    chk(done_cyc[0] == 0, "R3", "hit beside misses", done_cyc[0], 0);
    chk(done_cyc[1] == LAT + 1, "R11", "port1 first", done_cyc[1], LAT + 1);
    chk(done_cyc[2] == 2 * LAT + 3, "R11", "port2 waits", done_cyc[2], 2 * LAT + 3);
    chk(fetches - f0 == 2, "R11", "two fetches", fetches - f0, 2);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_cold_miss();
    t_hits();
    t_multi_hit();
    t_disabled();
    t_flush();
    t_flush_in_fill();
    t_arb();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end
endmodule